// File: doc/BRIEF.md
# DDR2 Bank Close/Reopen Timing Guard

This block watches the command bus between a memory controller's command issuer and a four-bank DDR2-style SDRAM. Every cycle it decodes the active-low chip-select, row-strobe, column-strobe and write-enable lines, together with the bank address and the A10 auto-all bit. From that it keeps, for each bank, an open/closed flag and three down-counters:

- time since activate, which must reach tRAS before a close;
- read-to-close spacing, which is additive latency plus half the burst length;
- time since close, which must reach tRP before a reopen.

The issuer reads the per-bank `pre_ok` / `act_ok` flags and the combined `pre_all_ok` flag to decide what it may send this cycle. A command that breaks a spacing rule is still applied to the tracked state, so the model stays in step with the memory. One cycle later it raises `viol` for a single cycle and reports the offending bank on `viol_bank`.

All timing values are plain configuration inputs, sampled whenever a command loads a counter. There is no streaming data path: every pin is a level-sampled control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `ddr2_bank_guard`

## Requirements
- R1: With `cs_n` low, the strobe pattern on {`ras_n`,`cas_n`,`we_n`} is decoded as follows: 3'b011 is an activate, 3'b101 is a read and 3'b010 is a precharge. An activate to a bank makes that bank's `act_ok` low on the next cycle.
- R2: A precharge with `a10` = 0 closes only the bank numbered {`ba[1]`,`ba[0]`}: 0 is 2'b00, 1 is 2'b01, 2 is 2'b10 and 3 is 2'b11. Every other bank keeps its open/closed state.
- R3: A precharge with `a10` = 1 closes every open bank, whatever the value of `ba`.
- R4: Take a precharge to an open bank that is sampled k clock edges after that bank's activate. It meets the activate rule only when k >= `cfg_tras`. `pre_ok[b]` shows this in advance.
- R5: Take a precharge sampled j edges after a read to the same open bank. It is legal only when j >= `cfg_al` + BL/2, where BL/2 is 2 when `cfg_bl8` = 0 and 4 when `cfg_bl8` = 1.
- R6: `act_ok[b]` is low while bank b is open. After a precharge closes bank b, an activate sampled k edges later is legal only when k >= `cfg_trp`. An activate to a bank that is still open is a violation.
- R7: `pre_all_ok` is high exactly when every open bank meets both R4 and R5. Closed banks never hold it low.
- R8: An illegal activate or precharge raises `viol` for one cycle, on the cycle after the offending edge. `viol_bank` then carries the offending bank, or the lowest-numbered offending bank for an all-bank precharge. The command still updates the bank state.
- R9: A precharge to a bank that is already closed is legal, changes no state and does not restart that bank's tRP count.
- R10: A deselected cycle (`cs_n` high), a NOP (3'b111) and any other strobe pattern (for example a write, 3'b100) leave the open/closed state unchanged and raise no violation.
- R11: After reset all banks are closed, all counters are zero, `act_ok` = 4'b1111, `pre_ok` = 4'b1111, `pre_all_ok` = 1 and `viol` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Close-all select for precharge |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| cfg_tras | input | 5 | Minimum activate-to-precharge clocks |
| cfg_trp | input | 4 | Minimum precharge-to-activate clocks |
| pre_ok | output | 4 | Per bank: a precharge would be legal this cycle |
| act_ok | output | 4 | Per bank: an activate would be legal this cycle |
| pre_all_ok | output | 1 | An all-bank precharge would be legal this cycle |
| viol | output | 1 | One-cycle pulse after an illegal command |
| viol_bank | output | 2 | Bank that caused the last violation pulse |

## Verification
Two functions can land on the same clock edge.

The first pair is flagging a violation and recording the same command's state change. The bench sends a precharge or activate too early, then checks `viol` and `viol_bank` on the following cycle. It also checks that the bank was still closed or opened by that command, by watching `act_ok` with a one-cycle tRP.

The second pair is the all-bank close meeting banks whose timers stand at different points. The bench opens two banks on adjacent cycles and issues the close-all while only one of them has met tRAS. It then checks that the lowest offending bank is reported and that `pre_all_ok` tracked the slower bank.

The timing sweeps step the command distance through every value on both sides of each limit.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_ACT,
    CMD_READ,
    CMD_PRE,
    CMD_OTHER
  } bg_cmd_e;
endpackage

// File: rtl/bg_cmd_decode.sv
module bg_cmd_decode
  import bg_pkg::*;
(
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  output bg_cmd_e cmd
);
  always_comb begin
    cmd = CMD_OTHER;
    if (cs_n) begin
      cmd = CMD_IDLE;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_IDLE;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/bg_bank.sv
module bg_bank #(
  parameter int TRAS_W = 5,
  parameter int TRP_W  = 4,
  parameter int RTP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_hit,
  input  logic              rd_hit,
  input  logic              pre_hit,
  input  logic [TRAS_W-1:0] tras_ld,
  input  logic [RTP_W-1:0]  rtp_ld,
  input  logic [TRP_W-1:0]  trp_ld,
  output logic              pre_ok,
  output logic              act_ok
);
  logic              open_q;
  logic [TRAS_W-1:0] tras_q;
  logic [RTP_W-1:0]  rtp_q;
  logic [TRP_W-1:0]  trp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tras_q <= '0;
      rtp_q  <= '0;
      trp_q  <= '0;
    end else begin
      // saturating down-counts; a load on the same edge takes precedence
      if (tras_q != '0) tras_q <= tras_q - 1'b1;
      if (rtp_q  != '0) rtp_q  <= rtp_q  - 1'b1;
      if (trp_q  != '0) trp_q  <= trp_q  - 1'b1;
      if (act_hit) begin
        open_q <= 1'b1;
        tras_q <= tras_ld;
        rtp_q  <= '0;
      end else if (rd_hit) begin
        rtp_q  <= rtp_ld;
      end else if (pre_hit && open_q) begin
        open_q <= 1'b0;
        trp_q  <= trp_ld;
      end
    end
  end

  assign act_ok = !open_q && (trp_q == '0);
  assign pre_ok = !open_q || ((tras_q == '0) && (rtp_q == '0));
endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
  import bg_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int AL_W   = 3,
  parameter int TRAS_W = 5,
  parameter int TRP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic              a10,
  input  logic [AL_W-1:0]   cfg_al,
  input  logic              cfg_bl8,
  input  logic [TRAS_W-1:0] cfg_tras,
  input  logic [TRP_W-1:0]  cfg_trp,
  output logic [(1<<BA_W)-1:0] pre_ok,
  output logic [(1<<BA_W)-1:0] act_ok,
  output logic              pre_all_ok,
  output logic              viol,
  output logic [BA_W-1:0]   viol_bank
);
  localparam int NBANK = 1 << BA_W;
  localparam int RTP_W = AL_W + 1;

  bg_cmd_e cmd;

  bg_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  // counter load values: a limit of N clocks loads N-1
  logic [TRAS_W-1:0] tras_ld;
  logic [TRP_W-1:0]  trp_ld;
  logic [RTP_W-1:0]  rtp_sum;
  logic [RTP_W-1:0]  rtp_ld;

  assign tras_ld = (cfg_tras == '0) ? '0 : cfg_tras - 1'b1;
  assign trp_ld  = (cfg_trp  == '0) ? '0 : cfg_trp  - 1'b1;
  assign rtp_sum = RTP_W'(cfg_al) + (cfg_bl8 ? RTP_W'(4) : RTP_W'(2));
  assign rtp_ld  = rtp_sum - 1'b1;

  logic [NBANK-1:0] act_hit, rd_hit, pre_hit, bad;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign act_hit[b] = (cmd == CMD_ACT)  && (ba == BA_W'(b));
    assign rd_hit[b]  = (cmd == CMD_READ) && (ba == BA_W'(b));
    assign pre_hit[b] = (cmd == CMD_PRE)  && (a10 || (ba == BA_W'(b)));

    bg_bank #(
      .TRAS_W (TRAS_W),
      .TRP_W  (TRP_W),
      .RTP_W  (RTP_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_hit (act_hit[b]),
      .rd_hit  (rd_hit[b]),
      .pre_hit (pre_hit[b]),
      .tras_ld (tras_ld),
      .rtp_ld  (rtp_ld),
      .trp_ld  (trp_ld),
      .pre_ok  (pre_ok[b]),
      .act_ok  (act_ok[b])
    );

    assign bad[b] = (act_hit[b] && !act_ok[b]) || (pre_hit[b] && !pre_ok[b]);
  end

  assign pre_all_ok = &pre_ok;

  // lowest-numbered offending bank
  logic [BA_W-1:0] first_bad;
  always_comb begin
    first_bad = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (bad[b]) first_bad = BA_W'(b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_bank <= '0;
    end else begin
      viol <= |bad;
      if (|bad) viol_bank <= first_bad;
    end
  end
endmodule

// File: rtl/bg_guard_chk.sv
module bg_guard_chk #(
  parameter int BA_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic [BA_W-1:0]        ba,
  input logic                   a10,
  input logic [(1<<BA_W)-1:0]   pre_ok,
  input logic [(1<<BA_W)-1:0]   act_ok,
  input logic                   pre_all_ok,
  input logic                   viol,
  input logic [BA_W-1:0]        viol_bank
);
  localparam int NBANK = 1 << BA_W;

  logic is_act, is_pre, is_nop;
  assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
  assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_nop =  cs_n || (ras_n && cas_n && we_n);

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    // R1: an activate leaves the bank open
    a_r1_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && ba == BA_W'(b)) |=> !act_ok[b]);
    // R2: a single-bank precharge leaves that bank closable
    a_r2_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && !a10 && ba == BA_W'(b)) |=> pre_ok[b]);
    // R4: idle cycles never take back a precharge permission
    a_r4_pre_ok_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (is_nop && pre_ok[b]) |=> pre_ok[b]);
    // R9: closing an already closed, ready bank keeps it ready
    a_r9_closed_pre_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && !a10 && ba == BA_W'(b) && act_ok[b]) |=> act_ok[b]);
  end

  // R3: after a close-all every bank is closed
  a_r3_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10) |=> pre_all_ok);
  // R7: a close-all issued while permitted raises no violation
  a_r7_all_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10 && pre_all_ok) |=> !viol);
  // R8: a violation always follows an activate or precharge
  a_r8_viol_source: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(is_act || is_pre));
  // R10: idle cycles raise no violation
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |=> !viol);
endmodule

bind ddr2_bank_guard bg_guard_chk #(.BA_W(BA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .a10        (a10),
  .pre_ok     (pre_ok),
  .act_ok     (act_ok),
  .pre_all_ok (pre_all_ok),
  .viol       (viol),
  .viol_bank  (viol_bank)
);

// File: tb/ddr2_bank_guard_test.sv
module ddr2_bank_guard_test;
  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_WR  = 3'b100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic       a10 = 1'b0;
  logic [2:0] cfg_al = '0;
  logic       cfg_bl8 = 1'b0;
  logic [4:0] cfg_tras = 5'd1;
  logic [3:0] cfg_trp = 4'd1;
  logic [3:0] pre_ok, act_ok;
  logic       pre_all_ok, viol;
  logic [1:0] viol_bank;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr2_bank_guard uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
    .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .pre_ok(pre_ok), .act_ok(act_ok),
    .pre_all_ok(pre_all_ok), .viol(viol), .viol_bank(viol_bank)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic raw(input logic cs, input logic [2:0] rcw, input logic [1:0] b, input logic a);
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = a;
    @(negedge clk);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
  endtask

  task automatic issue(input logic [2:0] rcw, input logic [1:0] b, input logic a);
    raw(1'b0, rcw, b, a);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input int tras, input int trp);
    cfg_tras = 5'(tras); cfg_trp = 4'(trp); cfg_al = '0; cfg_bl8 = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1, 1);
    // R11: reset state
    chk("R11 act_ok", act_ok, 15);
    chk("R11 pre_ok", pre_ok, 15);
    chk("R11 pre_all_ok", pre_all_ok, 1);
    chk("R11 viol", viol, 0);

    // R4: activate-to-precharge sweep
    for (int tr = 1; tr <= 6; tr++) begin
      for (int k = 1; k <= tr + 1; k++) begin
        do_reset(tr, 1);
        issue(C_ACT, 2'(k % 4), 1'b0);
        idle(k - 1);
        chk("R4 pre_ok", pre_ok[k % 4], (k >= tr) ? 1 : 0);
        issue(C_PRE, 2'(k % 4), 1'b0);
        chk("R4 viol", viol, (k < tr) ? 1 : 0);
        if (k < tr) chk("R8 viol_bank", viol_bank, k % 4);
        idle(1);
        chk("R8 one-cycle pulse", viol, 0);
      end
    end

    // R5: read-to-precharge sweep over AL and burst length
    for (int al = 0; al <= 3; al++) begin
      for (int b8 = 0; b8 <= 1; b8++) begin
        int lim;
        lim = al + (b8 ? 4 : 2);
        for (int j = 1; j <= lim + 1; j++) begin
          do_reset(1, 1);
          cfg_al = 3'(al); cfg_bl8 = b8[0];
          issue(C_ACT, 2'd1, 1'b0);
          issue(C_RD, 2'd1, 1'b0);
          idle(j - 1);
          chk("R5 pre_ok", pre_ok[1], (j >= lim) ? 1 : 0);
          issue(C_PRE, 2'd1, 1'b0);
          chk("R5 viol", viol, (j < lim) ? 1 : 0);
        end
      end
    end

    // R6 / R1: precharge-to-activate sweep
    for (int tp = 1; tp <= 5; tp++) begin
      for (int k = 1; k <= tp + 1; k++) begin
        do_reset(1, tp);
        issue(C_ACT, 2'd2, 1'b0);
        chk("R1 act opens", act_ok[2], 0);
        issue(C_PRE, 2'd2, 1'b0);
        idle(k - 1);
        chk("R6 act_ok", act_ok[2], (k >= tp) ? 1 : 0);
        issue(C_ACT, 2'd2, 1'b0);
        chk("R6 viol", viol, (k < tp) ? 1 : 0);
      end
    end
    do_reset(1, 1);
    issue(C_ACT, 2'd3, 1'b0);
    issue(C_ACT, 2'd3, 1'b0);
    chk("R6 act to open bank viol", viol, 1);
    chk("R6 act to open bank id", viol_bank, 3);

    // R2: single-bank targeting
    for (int b = 0; b < 4; b++) begin
      do_reset(1, 1);
      for (int o = 0; o < 4; o++) issue(C_ACT, 2'(o), 1'b0);
      issue(C_PRE, 2'(b), 1'b0);
      chk("R2 only target closed", act_ok, 1 << b);
    end

    // R3: close-all ignores bank bits
    do_reset(1, 1);
    issue(C_ACT, 2'd0, 1'b0);
    issue(C_ACT, 2'd3, 1'b0);
    issue(C_PRE, 2'd1, 1'b1);
    chk("R3 all closed", act_ok, 15);
    chk("R3 no viol", viol, 0);

    // R7: combined permission follows the slowest open bank
    do_reset(4, 3);
    issue(C_ACT, 2'd0, 1'b0);
    issue(C_ACT, 2'd2, 1'b0);
    idle(2);
    chk("R7 pre_ok mix", pre_ok, 4'b1011);
    chk("R7 pre_all_ok low", pre_all_ok, 0);
    idle(1);
    chk("R7 pre_all_ok high", pre_all_ok, 1);
    issue(C_PRE, 2'd1, 1'b1);
    chk("R7 clean close-all", viol, 0);
    chk("R3 tRP on closed banks", act_ok, 4'b1010);

    // R8: close-all violations and state still recorded
    do_reset(4, 1);
    issue(C_ACT, 2'd0, 1'b0);
    issue(C_ACT, 2'd2, 1'b0);
    idle(2);
    issue(C_PRE, 2'd0, 1'b1);
    chk("R8 all viol", viol, 1);
    chk("R8 all viol bank", viol_bank, 2);
    chk("R8 recorded", act_ok, 15);
    do_reset(4, 1);
    issue(C_ACT, 2'd0, 1'b0);
    issue(C_ACT, 2'd2, 1'b0);
    issue(C_PRE, 2'd3, 1'b1);
    chk("R8 lowest bank", viol_bank, 0);

    // R9: precharge to closed bank
    do_reset(1, 4);
    issue(C_PRE, 2'd1, 1'b0);
    chk("R9 closed pre viol", viol, 0);
    chk("R9 closed pre act_ok", act_ok, 15);
    issue(C_ACT, 2'd1, 1'b0);
    issue(C_PRE, 2'd1, 1'b0);
    issue(C_PRE, 2'd1, 1'b0);
    chk("R9 repeat pre viol", viol, 0);
    idle(2);
    chk("R9 tRP not restarted", act_ok[1], 1);

    // R10: deselect, write and NOP change nothing
    do_reset(1, 1);
    raw(1'b1, C_ACT, 2'd0, 1'b0);
    chk("R10 deselected act", act_ok, 15);
    issue(C_ACT, 2'd0, 1'b0);
    raw(1'b1, C_PRE, 2'd0, 1'b1);
    chk("R10 deselected pre", act_ok[0], 0);
    chk("R10 no viol", viol, 0);
    issue(C_WR, 2'd0, 1'b0);
    chk("R10 write no close", act_ok[0], 0);
    issue(3'b111, 2'd0, 1'b1);
    idle(3);
    chk("R10 nop keeps open", act_ok[0], 0);
    issue(C_PRE, 2'd0, 1'b0);
    chk("R1 pre decode closes", act_ok[0], 1);

    done = 1;
    report();
    $finish;
  end
endmodule